// File: doc/BRIEF.md
# Packet Buffer with Whole-Packet and Cut-Through Release

This block holds packets travelling in one direction of a PCI Express style link. A user-side source pushes packets one word per accepted cycle. Each word carries a 64-bit payload, a few extra upper bits, and start and end markers. A link-side consumer drains the words in the same order. Storage is a simple dual-port RAM with a registered read port. Read control looks ahead so that words reach the output port two clock edges after the RAM read is issued.

A single mode input picks when a packet becomes visible to the reader. With `cut_through` low, no word of a packet is offered until the packet's last word has been written. With `cut_through` high, the reader may follow the writer word by word and pauses whenever it catches up. The mode is meant to be changed only while no packet is half written. Buffer space is freed only when the consumer takes a word at the output port. Words held in the read pipeline therefore still count against capacity.

Top module: `pkt_spill_buffer`

## Requirements
- R1: Right after reset, `rd_valid` is 0 and `wr_ready` is 1.
- R2: Every accepted word leaves in acceptance order, with its start flag, end flag and all `DATA_W+EXTRA_W` data bits unchanged. This includes the extra upper bits, which are carried but never interpreted.
- R3: The buffer holds exactly 2^`ADDR_W` words that the consumer has not yet taken. `wr_ready` is 0 exactly when that many are held. A word presented while `wr_ready` is 0 is not stored. `wr_ready` returns to 1 one edge after the consumer takes a word.
- R4: With `cut_through` = 0, no word of a packet appears at the output before the word with `wr_eop` = 1 has been accepted.
- R5: With `cut_through` = 0, an empty buffer and `rd_ready` = 1, `rd_valid` goes high after the second rising edge that follows the edge accepting the end word.
- R6: With `cut_through` = 1, an empty buffer and `rd_ready` = 1, a start word is offered after the second rising edge that follows its acceptance, before the packet is complete.
- R7: The reader never offers a word that has not been written. In cut-through mode, once it has caught up with the writer, `rd_valid` stays 0 until more words arrive.
- R8: While `rd_valid` = 1 and `rd_ready` = 0, the next cycle keeps `rd_valid` = 1 and leaves `rd_data`, `rd_sop` and `rd_eop` unchanged.
- R9: When the buffer is full and `rd_ready` is held at 1, the output presents one word on every clock for the whole drain of 2^`ADDR_W` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cut_through | input | 1 | 1: release words before the end word; 0: release whole packets only |
| wr_valid | input | 1 | Source presents a word |
| wr_ready | output | 1 | Buffer can take a word this cycle |
| wr_sop | input | 1 | Presented word starts a packet |
| wr_eop | input | 1 | Presented word ends a packet |
| wr_data | input | DATA_W+EXTRA_W | Payload plus extra upper bits |
| rd_valid | output | 1 | Output word is valid |
| rd_ready | input | 1 | Consumer takes the output word |
| rd_sop | output | 1 | Output word starts a packet |
| rd_eop | output | 1 | Output word ends a packet |
| rd_data | output | DATA_W+EXTRA_W | Output payload plus extra bits |

## Verification
Each result has a fixed arrival time. `wr_ready` reflects the occupancy after the last edge. A word becomes visible at the output two edges after it is released, that is, two edges after the end word in whole-packet mode or after the word itself in cut-through mode. The bench drives inputs just after a rising edge and samples on the falling edge. A behavioural queue model advances by the handshakes it saw at the previous falling edge, so every comparison falls in the cycle where the result is due. Directed sequences count exactly zero, zero, then one falling edge for the two release latencies, and they watch an idle window after the reader catches up in cut-through mode.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  // Release policy selected by the mode input.
  typedef enum logic {
    REL_WHOLE = 1'b0,
    REL_CUT   = 1'b1
  } release_mode_e;

  // Output staging capacity: covers two-cycle read latency plus back-pressure.
  localparam int OUT_DEPTH = 4;
  localparam int OUT_AW    = 2;
endpackage

// File: rtl/pktbuf_ram.sv
module pktbuf_ram #(
  parameter int WORD_W = 70,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pktbuf_wr_ctrl.sv
module pktbuf_wr_ctrl #(
  parameter int ADDR_W = 5,
  localparam int PW = ADDR_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic          wr_eop,
  input  logic [PW-1:0] rel_ptr,
  output logic          wr_ready,
  output logic          wr_fire,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] commit_ptr
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  logic [PW-1:0] used;

  // Occupancy counts every word not yet taken at the output port.
  assign used     = wr_ptr - rel_ptr;
  assign wr_ready = (used != DEPTH_P);
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
    end else if (wr_fire) begin
      wr_ptr <= wr_ptr + PW'(1);
      if (wr_eop) commit_ptr <= wr_ptr + PW'(1);
    end
  end
endmodule

// File: rtl/pktbuf_rd_ctrl.sv
module pktbuf_rd_ctrl
  import pktbuf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 70,
  localparam int PW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cut_through,
  input  logic [PW-1:0]     wr_ptr,
  input  logic [PW-1:0]     commit_ptr,
  input  logic [WORD_W-1:0] ram_q,
  input  logic              rd_ready,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic [PW-1:0]     rd_ptr,
  output logic [PW-1:0]     rel_ptr,
  output logic              rd_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int CW = OUT_AW + 1;

  release_mode_e mode;
  logic [PW-1:0] limit, span_lim, span_wr;
  logic          has_word, room, v1, push, pop;
  logic [CW-1:0] cnt;
  logic [CW:0]   inflight;
  logic [OUT_AW-1:0] head, tail;
  logic [WORD_W-1:0] slot [OUT_DEPTH];

  // Readable span is measured against the mode-dependent limit and may
  // never exceed the span up to the raw write pointer.
  assign mode     = release_mode_e'(cut_through);
  assign limit    = (mode == REL_CUT) ? wr_ptr : commit_ptr;
  assign span_lim = limit - rd_ptr;
  assign span_wr  = wr_ptr - rd_ptr;
  assign has_word = (span_lim != '0) && (span_lim <= span_wr);

  // Issue only when every in-flight word has a guaranteed staging slot.
  assign inflight  = {1'b0, cnt} + (CW+1)'(v1);
  assign room      = inflight < (CW+1)'(OUT_DEPTH);
  assign ram_re    = has_word && room;
  assign ram_raddr = rd_ptr[ADDR_W-1:0];

  assign push     = v1;
  assign rd_valid = (cnt != '0);
  assign pop      = rd_valid && rd_ready;
  assign out_word = slot[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      rel_ptr <= '0;
      v1      <= 1'b0;
      head    <= '0;
      tail    <= '0;
      cnt     <= '0;
    end else begin
      v1 <= ram_re;
      if (ram_re) rd_ptr  <= rd_ptr + PW'(1);
      if (pop)    rel_ptr <= rel_ptr + PW'(1);
      if (push)   tail    <= tail + OUT_AW'(1);
      if (pop)    head    <= head + OUT_AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[tail] <= ram_q;
  end
endmodule

// File: rtl/pkt_spill_buffer.sv
module pkt_spill_buffer #(
  parameter int DATA_W  = 64,
  parameter int EXTRA_W = 4,
  parameter int ADDR_W  = 5,
  localparam int PAY_W  = DATA_W + EXTRA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cut_through,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_sop,
  input  logic             wr_eop,
  input  logic [PAY_W-1:0] wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             rd_sop,
  output logic             rd_eop,
  output logic [PAY_W-1:0] rd_data
);
  localparam int WORD_W = PAY_W + 2;
  localparam int PW     = ADDR_W + 1;

  logic              wr_fire, ram_re;
  logic [PW-1:0]     wr_ptr, commit_ptr, rd_ptr, rel_ptr;
  logic [ADDR_W-1:0] ram_raddr;
  logic [WORD_W-1:0] ram_q, out_word;

  pktbuf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_eop(wr_eop),
    .rel_ptr(rel_ptr), .wr_ready(wr_ready), .wr_fire(wr_fire),
    .wr_ptr(wr_ptr), .commit_ptr(commit_ptr)
  );

  pktbuf_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr[ADDR_W-1:0]),
    .wdata({wr_sop, wr_eop, wr_data}),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  pktbuf_rd_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .cut_through(cut_through),
    .wr_ptr(wr_ptr), .commit_ptr(commit_ptr), .ram_q(ram_q),
    .rd_ready(rd_ready), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .rd_ptr(rd_ptr), .rel_ptr(rel_ptr), .rd_valid(rd_valid),
    .out_word(out_word)
  );

  assign {rd_sop, rd_eop, rd_data} = out_word;
endmodule

// File: rtl/pkt_spill_buffer_chk.sv
module pkt_spill_buffer_chk #(
  parameter int ADDR_W = 5,
  parameter int PAY_W  = 68,
  localparam int PW    = ADDR_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cut_through,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             rd_sop,
  input logic             rd_eop,
  input logic [PAY_W-1:0] rd_data,
  input logic [PW-1:0]    wr_ptr,
  input logic [PW-1:0]    rd_ptr,
  input logic [PW-1:0]    rel_ptr,
  input logic [PW-1:0]    commit_ptr,
  input logic             ram_re
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  logic [PW-1:0] held, ahead, fill_span;
  assign held      = wr_ptr - rel_ptr;
  assign ahead     = wr_ptr - rd_ptr;
  assign fill_span = commit_ptr - rd_ptr;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    held <= DEPTH_P);

  // R3
  refused_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> $stable(wr_ptr));

  // R7
  no_overtake_chk: assert property (@(posedge clk) disable iff (rst)
    ahead <= DEPTH_P);

  // R4
  whole_packet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cut_through && ram_re) |-> (fill_span != '0 && fill_span <= ahead));

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> $past(ram_re, 2));

  // R8
  hold_output_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_sop) && $stable(rd_eop)));
endmodule

bind pkt_spill_buffer pkt_spill_buffer_chk #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst(rst), .cut_through(cut_through), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_data(rd_data),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rel_ptr(rel_ptr),
  .commit_ptr(commit_ptr), .ram_re(ram_re)
);

// File: tb/test_pkt_spill_buffer.sv
`timescale 1ns/1ps
module test_pkt_spill_buffer;
  localparam int DATA_W  = 64;
  localparam int EXTRA_W = 4;
  localparam int ADDR_W  = 5;
  localparam int PAY     = DATA_W + EXTRA_W;
  localparam int DEPTH   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cut_through = 1'b0;
  logic wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
  logic [PAY-1:0] wr_data = '0;
  logic rd_ready = 1'b0;
  logic wr_ready, rd_valid, rd_sop, rd_eop;
  logic [PAY-1:0] rd_data;

  always #2.5 clk = ~clk;

  pkt_spill_buffer #(.DATA_W(DATA_W), .EXTRA_W(EXTRA_W), .ADDR_W(ADDR_W)) i_pkt_spill_buffer (
    .clk(clk), .rst(rst), .cut_through(cut_through),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sop(rd_sop),
    .rd_eop(rd_eop), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_err    = 0;

  task automatic chk(input string req, input logic [127:0] act,
                     input logic [127:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [PAY+1:0] exp_q[$];
  int occ = 0, pushed = 0, popped = 0, committed = 0;
  bit hold_prev = 1'b0;
  logic [PAY+1:0] held_word;
  bit model_on = 1'b0;

  always @(negedge clk) begin
    if (model_on) begin
      chk("R3", wr_ready, occ != DEPTH, "wr_ready vs occupancy");
      if (hold_prev) begin
        chk("R8", rd_valid, 1'b1, "valid held under back-pressure");
        chk("R8", {rd_sop, rd_eop, rd_data}, held_word, "word held under back-pressure");
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk("R7", 1'b1, 1'b0, "word offered before being written");
        end else begin
          chk("R2", {rd_sop, rd_eop, rd_data}, exp_q[0], "output word");
          if (!cut_through)
            chk("R4", popped < committed, 1'b1, "word of unfinished packet offered");
        end
      end
      hold_prev = rd_valid && !rd_ready;
      held_word = {rd_sop, rd_eop, rd_data};
      if (rd_valid && rd_ready && exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        popped++;
        occ--;
      end
      if (wr_valid && wr_ready) begin
        exp_q.push_back({wr_sop, wr_eop, wr_data});
        pushed++;
        occ++;
        if (wr_eop) committed = pushed;
      end
    end
  end

  task automatic put(input bit s, input bit e, input logic [PAY-1:0] d);
    wr_valid = 1'b1; wr_sop = s; wr_eop = e; wr_data = d;
    forever begin
      @(negedge clk);
      if (wr_ready) break;
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  function automatic logic [PAY-1:0] rnd_word();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic put_pkt(input int n);
    for (int i = 0; i < n; i++) put(i == 0, i == n - 1, rnd_word());
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", rd_valid, 1'b0, "rd_valid after reset");
    chk("R1", wr_ready, 1'b1, "wr_ready after reset");
    model_on = 1'b1;
    @(posedge clk); #1;

    // Whole-packet release latency
    rd_ready = 1'b1;
    put_pkt(3);
    @(negedge clk); chk("R5", rd_valid, 1'b0, "edge 0 after end word");
    @(negedge clk); chk("R5", rd_valid, 1'b0, "edge 1 after end word");
    @(negedge clk); chk("R5", rd_valid, 1'b1, "edge 2 after end word");
    drain();

    // Incomplete packet is withheld in whole-packet mode
    put(1'b1, 1'b0, rnd_word());
    put(1'b0, 1'b0, rnd_word());
    put(1'b0, 1'b0, rnd_word());
    repeat (6) @(negedge clk);
    chk("R4", rd_valid, 1'b0, "incomplete packet withheld");
    @(posedge clk); #1;
    put(1'b0, 1'b1, rnd_word());
    drain();

    // Cut-through release and stall when caught up
    cut_through = 1'b1;
    put(1'b1, 1'b0, rnd_word());
    @(negedge clk); chk("R6", rd_valid, 1'b0, "edge 0 after start word");
    @(negedge clk); chk("R6", rd_valid, 1'b0, "edge 1 after start word");
    @(negedge clk); chk("R6", rd_valid, 1'b1, "edge 2 after start word");
    repeat (4) @(negedge clk);
    chk("R7", rd_valid, 1'b0, "reader stalls after catching up");
    @(posedge clk); #1;
    put(1'b0, 1'b0, rnd_word());
    put(1'b0, 1'b1, rnd_word());
    drain();
    cut_through = 1'b0;

    // Fill to capacity with consumer stalled
    rd_ready = 1'b0;
    for (int p = 0; p < DEPTH / 4; p++) put_pkt(4);
    @(negedge clk);
    chk("R3", wr_ready, 1'b0, "full after capacity words");
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_sop = 1'b1; wr_eop = 1'b1; wr_data = rnd_word();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R3", wr_ready, 1'b0, "write refused while full");
    end
    @(posedge clk); #1;
    wr_valid = 1'b0;
    rd_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk("R9", rd_valid, 1'b1, "continuous drain");
    end
    drain();

    // Random lengths and back-pressure in both modes
    for (int m = 0; m < 2; m++) begin
      cut_through = m[0];
      fork
        begin
          for (int p = 0; p < 40; p++) begin
            put_pkt(1 + int'($urandom_range(0, 6)));
            if ($urandom_range(0, 3) == 0) begin
              @(posedge clk); #1;
            end
          end
        end
        begin
          repeat (600) begin
            @(posedge clk); #1;
            rd_ready = ($urandom_range(0, 2) != 0);
          end
        end
      join
      rd_ready = 1'b1;
      drain();
    end

    chk("R2", exp_q.size(), 0, "words left undelivered");
    chk("R2", popped, pushed, "delivered vs accepted");
    finish_run();
  end
endmodule